// File: doc/BRIEF.md
# Cache Miss Line Refill Controller

This controller walks one cache level through the handling of a miss. It takes a miss together with the line address, the victim's address, the victim's dirty flag and the victim's line contents. If the victim is dirty, it first sends the victim out as a series of bus beats. It then issues a single line request to the next level and collects the returned line, one narrow beat at a time, into an assembly buffer. Finally it writes the whole line into the data array and the tag array in one cycle, with the valid bit set and the dirty bit clear, and pulses a resume strobe.

The next level answers with a fixed latency: the first beat of data appears a fixed number of cycles after the request cycle. Every beat occupies the bus for a fixed number of cycles. With the default parameters (64-byte line, 16-byte bus, 2 cycles per beat, latency 10) a clean-victim refill spans 19 cycles, from the request cycle to the fill cycle inclusive. Tag comparison, victim choice and the memory behind the bus belong to other blocks.

Top module: `miss_refill_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the controller is idle: `miss_ready`=1, `busy`=0, and `req_valid`, `wb_valid`, `fill_we` and `resume` are all 0. A reset during a miss abandons that miss.
- R2: A miss is accepted at a rising edge where `miss_valid` and `miss_ready` are both 1. From the next cycle, `busy`=1 and `miss_ready`=0 up to and including the resume cycle. A `miss_valid` raised while busy is ignored and produces no request.
- R3: For a clean victim, `req_valid` is a one-cycle pulse in the third cycle after the acceptance cycle. One cycle is spent on miss detection and one on victim selection.
- R4: For a dirty victim, the write-back starts in that same third cycle. `wb_valid` stays high while the beats are sent. Beat k (`wb_beat`=k, k=0..3) carries victim line bits [128k+127:128k]. A beat is taken at an edge that ends a cycle in which `wb_ready`=1 and the beat has already been on the bus for at least one earlier cycle. `wb_ready` is ignored in the first cycle of each beat. `req_valid` rises in the cycle after the fourth beat is taken.
- R5: The next level drives beat k of the line on `rsp_data` during cycles T+10+2k and T+11+2k, where T is the request cycle. The controller samples each beat at the edge that ends its second cycle and ignores `rsp_data` at all other times.
- R6: The assembled line places beat k in bits [128k+127:128k], in ascending address order.
- R7: `fill_we` is high for exactly cycle T+18. In that cycle it presents the assembled line on `fill_line` and the line-aligned address on `fill_addr`, with `fill_valid`=1 and `fill_dirty`=0.
- R8: `resume` is a one-cycle pulse in cycle T+19. `miss_ready` is 1 in the next cycle, so a waiting miss is accepted immediately.
- R9: `req_addr`, `fill_addr` and `wb_addr` carry the captured addresses with their low 6 bits (the byte offset within the line) forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Controller idle, can take a miss |
| miss_addr | input | 32 | Address that missed |
| victim_dirty | input | 1 | Chosen victim holds modified data |
| victim_addr | input | 32 | Address of the victim line |
| victim_line | input | 512 | Contents of the victim line |
| busy | output | 1 | A miss is being handled |
| wb_valid | output | 1 | Write-back beat on the bus |
| wb_ready | input | 1 | Next level takes the write-back beat |
| wb_addr | output | 32 | Line-aligned victim address |
| wb_beat | output | 2 | Index of the write-back beat |
| wb_data | output | 128 | Write-back beat data |
| req_valid | output | 1 | One-cycle line request |
| req_addr | output | 32 | Line-aligned request address |
| rsp_data | input | 128 | Refill beat data from the next level |
| fill_we | output | 1 | Data and tag array write strobe |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_line | output | 512 | Assembled line |
| fill_valid | output | 1 | Valid bit written to the tag |
| fill_dirty | output | 1 | Dirty bit written to the tag |
| resume | output | 1 | One-cycle pulse: execution may resume |

## Verification
The bench drives the refill data only inside the window in which each beat is valid, and drives a poison pattern outside it. A controller that samples a cycle early or late, or miscounts the latency, therefore assembles a wrong line or fills in the wrong cycle. Dirty misses are run with `wb_ready` held low for one cycle and for four cycles. A design that honours `wb_ready` in a beat's first cycle, or that issues the request before the last beat is taken, moves the request away from the cycle the bench expects. Misses offered while busy, a second miss already waiting when `resume` pulses, and a reset in the middle of a refill show whether the controller takes an unwanted request, wastes a cycle between misses, or leaves a stale refill running.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DETECT,
      ST_VICTIM,
      ST_WB,
      ST_REQ,
      ST_WAIT,
      ST_XFER,
      ST_FILL,
      ST_RESUME
   } mrc_state_e;
endpackage

// File: rtl/mrc_beat_counter.sv
// Counts cycles inside a beat and beats inside a line.
module mrc_beat_counter #(
   parameter int NBEATS   = 4,
   parameter int BEAT_CYC = 2,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             run,
   input  logic             take,
   output logic [IDX_W-1:0] beat_idx,
   output logic             beat_end,
   output logic             last_beat
);
   localparam int SUB_W = (BEAT_CYC > 1) ? $clog2(BEAT_CYC) : 1;

   logic             ripe;
   logic [IDX_W-1:0] idx_q;

   generate
      if (BEAT_CYC == 1) begin : g_single
         assign ripe = 1'b1;
      end else begin : g_multi
         logic [SUB_W-1:0] sub_q;
         always_ff @(posedge clk) begin
            if (rst || clr)
               sub_q <= '0;
            else if (run) begin
               if (beat_end)
                  sub_q <= '0;
               else if (sub_q != SUB_W'(BEAT_CYC - 1))
                  sub_q <= sub_q + 1'b1;
            end
         end
         assign ripe = (sub_q == SUB_W'(BEAT_CYC - 1));
      end
   endgenerate

   assign beat_end  = run && ripe && take;
   assign last_beat = (idx_q == IDX_W'(NBEATS - 1));
   assign beat_idx  = idx_q;

   always_ff @(posedge clk) begin
      if (rst || clr)
         idx_q <= '0;
      else if (beat_end)
         idx_q <= last_beat ? '0 : idx_q + 1'b1;
   end
endmodule

// File: rtl/mrc_line_buffer.sv
// Gathers incoming beats into one line, beat k into slot k.
module mrc_line_buffer #(
   parameter int NBEATS = 4,
   parameter int BEAT_W = 128,
   parameter int IDX_W  = 2
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [BEAT_W-1:0]        wr_data,
   output logic [NBEATS*BEAT_W-1:0] line
);
   generate
      for (genvar k = 0; k < NBEATS; k++) begin : g_slot
         logic [BEAT_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(k)))
               slot_q <= wr_data;
         end
         assign line[k*BEAT_W +: BEAT_W] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/mrc_wb_slicer.sv
// Selects one outgoing beat out of the captured victim line.
module mrc_wb_slicer #(
   parameter int NBEATS = 4,
   parameter int BEAT_W = 128,
   parameter int IDX_W  = 2
) (
   input  logic [NBEATS*BEAT_W-1:0] line,
   input  logic [IDX_W-1:0]         idx,
   output logic [BEAT_W-1:0]        beat
);
   logic [BEAT_W-1:0] slices [NBEATS];

   generate
      for (genvar k = 0; k < NBEATS; k++) begin : g_slice
         assign slices[k] = line[k*BEAT_W +: BEAT_W];
      end
   endgenerate

   assign beat = slices[idx];
endmodule

// File: rtl/miss_refill_ctrl.sv
module miss_refill_ctrl #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int BUS_BYTES  = 16,
   parameter int BEAT_CYC   = 2,
   parameter int REQ_LAT    = 10
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    miss_valid,
   output logic                    miss_ready,
   input  logic [ADDR_W-1:0]       miss_addr,
   input  logic                    victim_dirty,
   input  logic [ADDR_W-1:0]       victim_addr,
   input  logic [LINE_BYTES*8-1:0] victim_line,
   output logic                    busy,
   output logic                    wb_valid,
   input  logic                    wb_ready,
   output logic [ADDR_W-1:0]       wb_addr,
   output logic [$clog2(LINE_BYTES/BUS_BYTES)-1:0] wb_beat,
   output logic [BUS_BYTES*8-1:0]  wb_data,
   output logic                    req_valid,
   output logic [ADDR_W-1:0]       req_addr,
   input  logic [BUS_BYTES*8-1:0]  rsp_data,
   output logic                    fill_we,
   output logic [ADDR_W-1:0]       fill_addr,
   output logic [LINE_BYTES*8-1:0] fill_line,
   output logic                    fill_valid,
   output logic                    fill_dirty,
   output logic                    resume
);
   import mrc_pkg::*;

   localparam int LINE_W = LINE_BYTES * 8;
   localparam int BEAT_W = BUS_BYTES * 8;
   localparam int NBEATS = LINE_BYTES / BUS_BYTES;
   localparam int IDX_W  = $clog2(NBEATS);
   localparam int LAT_W  = $clog2(REQ_LAT);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

   // elaboration-time parameter checks
   generate
      if (LINE_BYTES % BUS_BYTES != 0) begin : g_bad_ratio
         $error("line size must be a whole number of bus beats");
      end
      if (NBEATS < 2 || (NBEATS & (NBEATS - 1)) != 0) begin : g_bad_beats
         $error("beat count must be a power of two, at least 2");
      end
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("line size must be a power of two");
      end
      if (REQ_LAT < 2) begin : g_bad_lat
         $error("request latency must be at least 2 cycles");
      end
      if (BEAT_CYC < 1) begin : g_bad_cyc
         $error("a beat needs at least one cycle");
      end
   endgenerate

   mrc_state_e           state_q, state_d;
   logic [ADDR_W-1:0]    addr_q, vaddr_q;
   logic                 vdirty_q;
   logic [LINE_W-1:0]    vline_q;
   logic [LAT_W-1:0]     lat_q;
   logic [IDX_W-1:0]     beat_idx;
   logic                 beat_end, last_beat;
   logic                 accept;

   assign accept = miss_valid && (state_q == ST_IDLE);

   mrc_beat_counter #(.NBEATS(NBEATS), .BEAT_CYC(BEAT_CYC), .IDX_W(IDX_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      ((state_q == ST_VICTIM) || (state_q == ST_REQ)),
      .run      ((state_q == ST_WB) || (state_q == ST_XFER)),
      .take     ((state_q == ST_WB) ? wb_ready : 1'b1),
      .beat_idx (beat_idx),
      .beat_end (beat_end),
      .last_beat(last_beat)
   );

   mrc_line_buffer #(.NBEATS(NBEATS), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_buf (
      .clk    (clk),
      .wr_en  ((state_q == ST_XFER) && beat_end),
      .wr_idx (beat_idx),
      .wr_data(rsp_data),
      .line   (fill_line)
   );

   mrc_wb_slicer #(.NBEATS(NBEATS), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_slc (
      .line(vline_q),
      .idx (beat_idx),
      .beat(wb_data)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_DETECT;
         ST_DETECT: state_d = ST_VICTIM;
         ST_VICTIM: state_d = vdirty_q ? ST_WB : ST_REQ;
         ST_WB:     if (beat_end && last_beat) state_d = ST_REQ;
         ST_REQ:    state_d = ST_WAIT;
         ST_WAIT:   if (lat_q == LAT_W'(REQ_LAT - 2)) state_d = ST_XFER;
         ST_XFER:   if (beat_end && last_beat) state_d = ST_FILL;
         ST_FILL:   state_d = ST_RESUME;
         ST_RESUME: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         vdirty_q <= 1'b0;
         lat_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q   <= miss_addr;
            vaddr_q  <= victim_addr;
            vdirty_q <= victim_dirty;
            vline_q  <= victim_line;
         end
         if (state_q == ST_REQ)
            lat_q <= '0;
         else if (state_q == ST_WAIT)
            lat_q <= lat_q + 1'b1;
      end
   end

   assign miss_ready = (state_q == ST_IDLE);
   assign busy       = (state_q != ST_IDLE);
   assign wb_valid   = (state_q == ST_WB);
   assign wb_addr    = vaddr_q & ALIGN_MASK;
   assign wb_beat    = beat_idx;
   assign req_valid  = (state_q == ST_REQ);
   assign req_addr   = addr_q & ALIGN_MASK;
   assign fill_we    = (state_q == ST_FILL);
   assign fill_addr  = addr_q & ALIGN_MASK;
   assign fill_valid = fill_we;
   assign fill_dirty = 1'b0;
   assign resume     = (state_q == ST_RESUME);

   AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
      miss_valid && miss_ready |=> busy && !req_valid && !wb_valid); // R2
   AST_BUSY_UNTIL_RESUME: assert property (@(posedge clk) disable iff (rst)
      busy && !resume |=> busy && !miss_ready); // R2
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> !req_valid && !fill_we); // R3
   AST_WB_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_beat)); // R4
   AST_WB_THEN_REQ: assert property (@(posedge clk) disable iff (rst)
      $fell(wb_valid) |-> req_valid); // R4
   AST_FILL_THEN_RESUME: assert property (@(posedge clk) disable iff (rst)
      fill_we |=> resume && !fill_we); // R7
   AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      resume |=> !resume && miss_ready && !busy); // R8
endmodule

// File: tb/miss_refill_ctrl_test.sv
module miss_refill_ctrl_test;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         miss_valid = 1'b0;
   logic         miss_ready;
   logic [31:0]  miss_addr = '0;
   logic         victim_dirty = 1'b0;
   logic [31:0]  victim_addr = '0;
   logic [511:0] victim_line = '0;
   logic         busy;
   logic         wb_valid;
   logic         wb_ready = 1'b0;
   logic [31:0]  wb_addr;
   logic [1:0]   wb_beat;
   logic [127:0] wb_data;
   logic         req_valid;
   logic [31:0]  req_addr;
   logic [127:0] rsp_data = '0;
   logic         fill_we;
   logic [31:0]  fill_addr;
   logic [511:0] fill_line;
   logic         fill_valid;
   logic         fill_dirty;
   logic         resume;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit finished = 1'b0;

   typedef struct {
      int           req_cyc;
      logic [31:0]  addr;
      logic [511:0] line;
      logic [31:0]  vaddr;
      logic [511:0] vline;
      int           stall;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   miss_refill_ctrl uut (.*);

   function automatic logic [127:0] rsp_beat(input logic [31:0] a, input int k);
      return {a, 32'(k), ~a, 32'hA5A5_0000 + 32'(k)};
   endfunction

   function automatic logic [511:0] line_of(input logic [31:0] a);
      logic [511:0] l;
      for (int k = 0; k < 4; k++) l[k*128 +: 128] = rsp_beat(a & 32'hFFFF_FFC0, k);
      return l;
   endfunction

   function automatic logic [511:0] vline_of(input logic [31:0] s);
      logic [511:0] l;
      for (int k = 0; k < 16; k++) l[k*32 +: 32] = s * 32'(k + 3) ^ 32'h5EED_0000;
      return l;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor, scoreboard and next-level model
   bit           active = 1'b0;
   int           rq = 0;
   exp_t         cur;
   int           wb_cnt = 0, wb_hold = 0, wb_taken = 0;

   always @(negedge clk) begin
      if (rst) begin
         active = 1'b0; wb_cnt = 0; wb_hold = 0; wb_taken = 0;
         wb_ready = 1'b0; rsp_data = '0;
      end else begin
         if (wb_valid) begin
            wb_cnt++;
            wb_ready = (exp_q.size() > 0) && (wb_cnt > exp_q[0].stall);
            chk(exp_q.size() > 0, "R4", "write-back with nothing pending", 0, 1);
            if (exp_q.size() > 0) begin
               chk(wb_beat == 2'(wb_taken), "R4", "write-back beat order", wb_beat, wb_taken);
               chk(wb_data == exp_q[0].vline[wb_taken*128 +: 128], "R4", "write-back data",
                   wb_data, exp_q[0].vline[wb_taken*128 +: 128]);
               chk(wb_addr == (exp_q[0].vaddr & 32'hFFFF_FFC0), "R9", "write-back address",
                   wb_addr, exp_q[0].vaddr & 32'hFFFF_FFC0);
            end
            wb_hold++;
            if (wb_ready && wb_hold >= 2) begin
               wb_taken++; wb_hold = 0;
            end
         end else begin
            wb_ready = 1'b0;
         end
         if (req_valid) begin
            chk(exp_q.size() > 0, "R2", "request with no accepted miss", 1, 0);
            if (exp_q.size() > 0) begin
               cur = exp_q.pop_front();
               chk(cyc == cur.req_cyc, "R3", "request cycle (R4 when dirty)", cyc, cur.req_cyc);
               chk(req_addr == (cur.addr & 32'hFFFF_FFC0), "R9", "request address",
                   req_addr, cur.addr & 32'hFFFF_FFC0);
               active = 1'b1; rq = cyc;
            end
            wb_cnt = 0; wb_hold = 0; wb_taken = 0;
         end
         if (fill_we) begin
            chk(active && cyc == rq + 18, "R7", "fill cycle", cyc, rq + 18);
            chk(fill_line == cur.line, "R6", "assembled line (R5 sampling)", fill_line, cur.line);
            chk(fill_valid && !fill_dirty, "R7", "tag bits valid/dirty", {fill_valid, fill_dirty}, 2'b10);
            chk(fill_addr == (cur.addr & 32'hFFFF_FFC0), "R9", "fill address",
                fill_addr, cur.addr & 32'hFFFF_FFC0);
         end
         if (resume) begin
            chk(active && cyc == rq + 19, "R8", "resume cycle", cyc, rq + 19);
            active = 1'b0;
         end
         if (active && (cyc - rq) >= 10 && (cyc - rq) < 18)
            rsp_data = rsp_beat(cur.addr & 32'hFFFF_FFC0, (cyc - rq - 10) / 2);
         else
            rsp_data = {4{32'hDEAD_BEEF}};
      end
   end

   // driver: offers a miss, pushes the expected outcome at acceptance
   task automatic do_miss(input logic [31:0] a, input bit dirty, input logic [31:0] va,
                          input int stall, input bit b2b);
      exp_t e;
      int   acc, rc;
      rc = -100;
      miss_valid = 1'b1; miss_addr = a; victim_dirty = dirty;
      victim_addr = va; victim_line = vline_of(va);
      while (!miss_ready) begin
         if (resume) rc = cyc;
         @(negedge clk);
      end
      acc = cyc;
      if (b2b) chk(acc == rc + 1, "R8", "back-to-back acceptance cycle", acc, rc + 1);
      e.req_cyc = dirty ? acc + 11 + ((stall > 1) ? stall - 1 : 0) : acc + 3;
      e.addr = a; e.line = line_of(a); e.vaddr = va; e.vline = vline_of(va); e.stall = stall;
      exp_q.push_back(e);
      @(negedge clk);
      miss_valid = 1'b0;
      chk(busy && !miss_ready, "R2", "busy after acceptance", {busy, miss_ready}, 2'b10);
   endtask

   task automatic wait_done();
      while (!resume) @(negedge clk);
      @(negedge clk);
      chk(miss_ready && !busy, "R8", "ready after resume", {miss_ready, busy}, 2'b10);
   endtask

   task automatic chk_idle(input string what);
      chk(miss_ready && !busy && !req_valid && !wb_valid && !fill_we && !resume, "R1", what,
          {miss_ready, busy, req_valid, wb_valid, fill_we, resume}, 6'b100000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("idle while in reset");
      rst = 1'b0;
      @(negedge clk);
      chk_idle("idle after reset");

      // R3 clean miss
      do_miss(32'h1234_5678, 1'b0, 32'h0, 0, 1'b0);
      wait_done();
      // R4 dirty victims, no stall, ready low only in a first beat cycle, long stall
      do_miss(32'h0000_A0C4, 1'b1, 32'h7700_1240, 0, 1'b0);
      wait_done();
      do_miss(32'h0BAD_F00D, 1'b1, 32'h3300_0080, 1, 1'b0);
      wait_done();
      do_miss(32'hFFFF_FFFF, 1'b1, 32'h1111_11C0, 4, 1'b0);
      wait_done();

      // R2 misses offered while busy are ignored
      do_miss(32'h4000_0100, 1'b0, 32'h0, 0, 1'b0);
      miss_valid = 1'b1; miss_addr = 32'h9999_9900; victim_dirty = 1'b1;
      for (int i = 0; i < 15; i++) begin
         chk(!miss_ready, "R2", "ready low while busy", miss_ready, 0);
         @(negedge clk);
      end
      miss_valid = 1'b0;
      wait_done();
      repeat (30) @(negedge clk);
      chk(exp_q.size() == 0 && !busy, "R2", "no extra miss taken", exp_q.size(), 0);

      // R8 back-to-back: second miss waits with valid held high
      do_miss(32'h2000_0040, 1'b1, 32'h5000_0000, 0, 1'b0);
      do_miss(32'h2000_0080, 1'b0, 32'h0, 0, 1'b1);
      wait_done();

      // R1 reset during a refill
      do_miss(32'h6000_0000, 1'b0, 32'h0, 0, 1'b0);
      repeat (8) @(negedge clk);
      rst = 1'b1;
      exp_q.delete();
      repeat (2) @(negedge clk);
      chk_idle("idle after mid-miss reset");
      rst = 1'b0;
      @(negedge clk);
      chk_idle("idle first cycle after reset");
      repeat (20) @(negedge clk);
      chk(!fill_we && !resume && !busy, "R1", "abandoned miss does not fill", {fill_we, resume, busy}, 0);
      do_miss(32'h6000_0040, 1'b1, 32'h0ACE_0000, 2, 1'b0);
      wait_done();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule